// File: doc/BRIEF.md
# Four-Bit Microprogrammed Slice Datapath

This block is one four-bit slice of a microprogrammed processor datapath. Each clock cycle a nine-bit microinstruction picks two ALU operands, an ALU operation and a destination. The operands come from a sixteen-word register file with two read ports, a working register Q, a direct data input or constant zero. The destination code decides where the result goes: the register file, Q, or nowhere. It also decides whether the result and Q move one place toward the most significant bit or toward the least significant bit, and what appears on the Y output.

The register file and Q load on the rising clock edge. The read ports, the ALU result, Y and all flags are combinational from the current state and inputs. Wider words are built by placing slices side by side. The serial shift pins of neighbouring slices are joined, and the carry, generate and propagate outputs feed a ripple chain or a lookahead unit. Data moves every cycle under microcode control, so the block has no handshake pins. An active-low asynchronous reset clears every register-file word and Q.

Top module: `slice4_alu`

## Requirements
- R1: The register file holds 16 words of 4 bits. Port A reads the word at addr_a, and port B reads and writes the word at addr_b. Reset clears every word and Q to 0.
- R2: instr[2:0] selects the operand pair (R,S): 000 (A,Q), 001 (A,B), 010 (0,Q), 011 (0,B), 100 (0,A), 101 (D,A), 110 (D,Q), 111 (D,0).
- R3: instr[5:3] selects the operation F: 000 R+S+c_in, 001 S+~R+c_in, 010 R+~S+c_in, 011 R|S, 100 R&S, 101 ~R&S, 110 R^S, 111 ~(R^S).
- R4: For the three arithmetic codes, c_out is the carry out of bit 3 and ovf is the XOR of the carries into and out of bit 3. prop is 1 when every bit of the two adder inputs has at least one 1. gen is the carry out that c_in = 0 would give. For the logic codes, c_out, ovf, gen and prop are all 0.
- R5: zero is 1 exactly when F is 0000, and sign equals F[3], for every destination code.
- R6: instr[8:6] = 000 loads F into Q, leaves the register file unchanged, and puts F on Y.
- R7: Destination 001 writes neither the register file nor Q, and puts F on Y.
- R8: Destinations 010 and 011 write F into word addr_b. Code 010 puts the port-A word on Y, and code 011 puts F on Y.
- R9: Codes 100 and 101 write F shifted toward bit 0 into word addr_b, with rf_dn_in entering bit 3 and F[0] driven on rf_dn_out. Code 100 also shifts Q the same way, with q_dn_in entering bit 3 and Q[0] driven on q_dn_out.
- R10: Codes 110 and 111 write F shifted toward bit 3 into word addr_b, with rf_up_in entering bit 0 and F[3] driven on rf_up_out. Code 110 also shifts Q the same way, with q_up_in entering bit 0 and Q[3] driven on q_up_out.
- R11: Under codes 101 and 111, Q keeps its value. Every shift-out pin whose shift is not in progress is driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 9 | Microinstruction: [8:6] destination, [5:3] operation, [2:0] operands |
| addr_a | input | 4 | Read-port A word address |
| addr_b | input | 4 | Read/write-port B word address |
| d_in | input | 4 | Direct data operand |
| c_in | input | 1 | Carry into bit 0 |
| y | output | 4 | Data output (F or port-A word) |
| c_out | output | 1 | Carry out of bit 3 |
| gen | output | 1 | Slice carry generate |
| prop | output | 1 | Slice carry propagate |
| ovf | output | 1 | Signed overflow |
| zero | output | 1 | F is all zeros |
| sign | output | 1 | Most significant bit of F |
| rf_dn_in | input | 1 | Bit entering bit 3 on a register-file down shift |
| rf_dn_out | output | 1 | Bit 0 of F leaving on a down shift |
| rf_up_in | input | 1 | Bit entering bit 0 on a register-file up shift |
| rf_up_out | output | 1 | Bit 3 of F leaving on an up shift |
| q_dn_in | input | 1 | Bit entering bit 3 on a Q down shift |
| q_dn_out | output | 1 | Bit 0 of Q leaving on a down shift |
| q_up_in | input | 1 | Bit entering bit 0 on a Q up shift |
| q_up_out | output | 1 | Bit 3 of Q leaving on an up shift |

## Verification
The hardest behaviour to observe is what a destination code does not do. A stray write to the register file or to Q under codes 000, 001, 101 or 111 leaves no mark on any pin in that cycle. The stimulus therefore follows each destination step with read-back steps, using the (0,A) and (0,Q) operand pairs with R+S and destination 001, and compares every word it touched and Q against a shadow copy. Overflow and the generate/propagate outputs need chosen operands. Registers are preloaded with 0111, 0001 and 1000 so that signed overflow, carry out and a full propagate chain are each produced on purpose.

// File: rtl/slice4_pkg.sv
package slice4_pkg;
  typedef enum logic [2:0] {
    SRC_AQ = 3'd0, SRC_AB = 3'd1, SRC_ZQ = 3'd2, SRC_ZB = 3'd3,
    SRC_ZA = 3'd4, SRC_DA = 3'd5, SRC_DQ = 3'd6, SRC_DZ = 3'd7
  } src_e;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0, FN_SUBR = 3'd1, FN_SUBS = 3'd2, FN_OR = 3'd3,
    FN_AND = 3'd4, FN_NRAS = 3'd5, FN_XOR = 3'd6, FN_XNOR = 3'd7
  } fn_e;

  typedef enum logic [2:0] {
    DST_QLD  = 3'd0, DST_NONE = 3'd1, DST_RFA  = 3'd2, DST_RFF  = 3'd3,
    DST_DNQ  = 3'd4, DST_DN   = 3'd5, DST_UPQ  = 3'd6, DST_UP   = 3'd7
  } dst_e;
endpackage

// File: rtl/slice4_regfile.sv
module slice4_regfile #(
  parameter int W     = 4,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr_b] <= wdata;
    end
  end

  assign rdata_a = mem[addr_a];
  assign rdata_b = mem[addr_b];
endmodule

// File: rtl/slice4_core_alu.sv
module slice4_core_alu
  import slice4_pkg::*;
#(
  parameter int W = 4
) (
  input  src_e         src,
  input  fn_e          fn,
  input  logic [W-1:0] a_dat,
  input  logic [W-1:0] b_dat,
  input  logic [W-1:0] q_dat,
  input  logic [W-1:0] d_dat,
  input  logic         c_in,
  output logic [W-1:0] f,
  output logic         c_out,
  output logic         gen,
  output logic         prop,
  output logic         ovf
);
  logic [W-1:0] r, s, op_a, op_b, sum;
  logic [W:0]   cy;
  logic         arith, g_acc, p_acc;

  always_comb begin
    unique case (src)
      SRC_AQ:  begin r = a_dat; s = q_dat; end
      SRC_AB:  begin r = a_dat; s = b_dat; end
      SRC_ZQ:  begin r = '0;    s = q_dat; end
      SRC_ZB:  begin r = '0;    s = b_dat; end
      SRC_ZA:  begin r = '0;    s = a_dat; end
      SRC_DA:  begin r = d_dat; s = a_dat; end
      SRC_DQ:  begin r = d_dat; s = q_dat; end
      default: begin r = d_dat; s = '0;    end
    endcase
  end

  always_comb begin
    arith = (fn == FN_ADD) || (fn == FN_SUBR) || (fn == FN_SUBS);
    op_a  = (fn == FN_SUBR) ? ~r : r;
    op_b  = (fn == FN_SUBS) ? ~s : s;
    cy[0] = c_in;
    g_acc = 1'b0;
    p_acc = 1'b1;
    for (int i = 0; i < W; i++) begin
      sum[i]  = op_a[i] ^ op_b[i] ^ cy[i];
      cy[i+1] = (op_a[i] & op_b[i]) | ((op_a[i] ^ op_b[i]) & cy[i]);
      g_acc   = (op_a[i] & op_b[i]) | ((op_a[i] | op_b[i]) & g_acc);
      p_acc   = p_acc & (op_a[i] | op_b[i]);
    end
  end

  always_comb begin
    unique case (fn)
      FN_OR:   f = r | s;
      FN_AND:  f = r & s;
      FN_NRAS: f = ~r & s;
      FN_XOR:  f = r ^ s;
      FN_XNOR: f = ~(r ^ s);
      default: f = sum;
    endcase
    c_out = arith & cy[W];
    ovf   = arith & (cy[W] ^ cy[W-1]);
    gen   = arith & g_acc;
    prop  = arith & p_acc;
  end
endmodule

// File: rtl/slice4_dest.sv
module slice4_dest
  import slice4_pkg::*;
#(
  parameter int W = 4
) (
  input  dst_e         dst,
  input  logic [W-1:0] f,
  input  logic [W-1:0] q_cur,
  input  logic [W-1:0] a_dat,
  input  logic         rf_dn_in,
  input  logic         rf_up_in,
  input  logic         q_dn_in,
  input  logic         q_up_in,
  output logic         rf_we,
  output logic [W-1:0] rf_wdata,
  output logic         q_we,
  output logic [W-1:0] q_next,
  output logic [W-1:0] y,
  output logic         rf_dn_out,
  output logic         rf_up_out,
  output logic         q_dn_out,
  output logic         q_up_out
);
  logic [W-1:0] f_dn, f_up, q_dn, q_up;

  assign f_dn = {rf_dn_in, f[W-1:1]};
  assign f_up = {f[W-2:0], rf_up_in};
  assign q_dn = {q_dn_in, q_cur[W-1:1]};
  assign q_up = {q_cur[W-2:0], q_up_in};

  always_comb begin
    rf_we     = 1'b0;
    rf_wdata  = f;
    q_we      = 1'b0;
    q_next    = q_cur;
    y         = f;
    rf_dn_out = 1'b0;
    rf_up_out = 1'b0;
    q_dn_out  = 1'b0;
    q_up_out  = 1'b0;
    unique case (dst)
      DST_QLD:  begin q_we = 1'b1; q_next = f; end
      DST_NONE: ;
      DST_RFA:  begin rf_we = 1'b1; y = a_dat; end
      DST_RFF:  rf_we = 1'b1;
      DST_DNQ:  begin
        rf_we = 1'b1; rf_wdata = f_dn; rf_dn_out = f[0];
        q_we  = 1'b1; q_next   = q_dn; q_dn_out  = q_cur[0];
      end
      DST_DN:   begin rf_we = 1'b1; rf_wdata = f_dn; rf_dn_out = f[0]; end
      DST_UPQ:  begin
        rf_we = 1'b1; rf_wdata = f_up; rf_up_out = f[W-1];
        q_we  = 1'b1; q_next   = q_up; q_up_out  = q_cur[W-1];
      end
      default:  begin rf_we = 1'b1; rf_wdata = f_up; rf_up_out = f[W-1]; end
    endcase
  end
endmodule

// File: rtl/slice4_alu.sv
module slice4_alu
  import slice4_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [8:0]    instr,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  input  logic [W-1:0]  d_in,
  input  logic          c_in,
  output logic [W-1:0]  y,
  output logic          c_out,
  output logic          gen,
  output logic          prop,
  output logic          ovf,
  output logic          zero,
  output logic          sign,
  input  logic          rf_dn_in,
  output logic          rf_dn_out,
  input  logic          rf_up_in,
  output logic          rf_up_out,
  input  logic          q_dn_in,
  output logic          q_dn_out,
  input  logic          q_up_in,
  output logic          q_up_out
);
  src_e         src;
  fn_e          fn;
  dst_e         dst;
  logic [W-1:0] a_rd, b_rd, f, rf_wdata, q_reg, q_next;
  logic         rf_we, q_we;

  assign src = src_e'(instr[2:0]);
  assign fn  = fn_e'(instr[5:3]);
  assign dst = dst_e'(instr[8:6]);

  slice4_regfile #(.W(W), .DEPTH(DEPTH)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .addr_a(addr_a), .addr_b(addr_b),
    .wdata(rf_wdata), .rdata_a(a_rd), .rdata_b(b_rd)
  );

  slice4_core_alu #(.W(W)) u_alu (
    .src(src), .fn(fn), .a_dat(a_rd), .b_dat(b_rd), .q_dat(q_reg),
    .d_dat(d_in), .c_in(c_in), .f(f), .c_out(c_out), .gen(gen),
    .prop(prop), .ovf(ovf)
  );

  slice4_dest #(.W(W)) u_dst (
    .dst(dst), .f(f), .q_cur(q_reg), .a_dat(a_rd),
    .rf_dn_in(rf_dn_in), .rf_up_in(rf_up_in), .q_dn_in(q_dn_in), .q_up_in(q_up_in),
    .rf_we(rf_we), .rf_wdata(rf_wdata), .q_we(q_we), .q_next(q_next), .y(y),
    .rf_dn_out(rf_dn_out), .rf_up_out(rf_up_out), .q_dn_out(q_dn_out), .q_up_out(q_up_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_reg <= '0;
    else if (q_we) q_reg <= q_next;
  end

  assign zero = (f == '0);
  assign sign = f[W-1];
endmodule

// File: rtl/slice4_alu_chk.sv
module slice4_alu_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [8:0]   instr,
  input logic [W-1:0] y,
  input logic [W-1:0] a_rd,
  input logic [W-1:0] q_reg,
  input logic [W-1:0] f,
  input logic         rf_we,
  input logic         c_out,
  input logic         gen,
  input logic         prop,
  input logic         ovf,
  input logic         zero,
  input logic         sign,
  input logic         rf_dn_out,
  input logic         rf_up_out,
  input logic         q_dn_out,
  input logic         q_up_out
);
  logic [2:0] dst, fn;
  assign dst = instr[8:6];
  assign fn  = instr[5:3];

  AST_Q_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (dst == 3'b000) |=> (q_reg == $past(f)));  // R6
  AST_NO_RF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (dst == 3'b000 || dst == 3'b001) |-> !rf_we);  // R7
  AST_Y_PORT_A: assert property (@(posedge clk) disable iff (!rst_n)
    (dst == 3'b010) |-> (y == a_rd));  // R8
  AST_Q_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dst == 3'b001 || dst == 3'b101 || dst == 3'b111) |=> $stable(q_reg));  // R11
  AST_LOGIC_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (fn >= 3'b011) |-> (!c_out && !ovf && !gen && !prop));  // R4
  AST_ZERO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (dst != 3'b010) |-> ((zero == (y == '0)) && (sign == y[W-1])));  // R5
  AST_DN_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (dst[2:1] != 2'b10) |-> (!rf_dn_out && !q_dn_out));  // R9
  AST_UP_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (dst[2:1] != 2'b11) |-> (!rf_up_out && !q_up_out));  // R10
endmodule

bind slice4_alu slice4_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr(instr), .y(y), .a_rd(a_rd), .q_reg(q_reg),
  .f(f), .rf_we(rf_we), .c_out(c_out), .gen(gen), .prop(prop), .ovf(ovf),
  .zero(zero), .sign(sign), .rf_dn_out(rf_dn_out), .rf_up_out(rf_up_out),
  .q_dn_out(q_dn_out), .q_up_out(q_up_out)
);

// File: tb/test_slice4_alu.sv
module test_slice4_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] instr = '0;
  logic [3:0] addr_a = '0, addr_b = '0, d_in = '0;
  logic       c_in = 1'b0;
  logic [3:0] y;
  logic       c_out, gen, prop, ovf, zero, sign;
  logic       rf_dn_in = 1'b0, rf_up_in = 1'b0, q_dn_in = 1'b0, q_up_in = 1'b0;
  logic       rf_dn_out, rf_up_out, q_dn_out, q_up_out;

  int nchk = 0;
  int nbad = 0;
  logic [3:0] sh_rf [16];
  logic [3:0] sh_q;

  always #5 clk = ~clk;

  slice4_alu i_slice4_alu (
    .clk(clk), .rst_n(rst_n), .instr(instr), .addr_a(addr_a), .addr_b(addr_b),
    .d_in(d_in), .c_in(c_in), .y(y), .c_out(c_out), .gen(gen), .prop(prop),
    .ovf(ovf), .zero(zero), .sign(sign),
    .rf_dn_in(rf_dn_in), .rf_dn_out(rf_dn_out), .rf_up_in(rf_up_in), .rf_up_out(rf_up_out),
    .q_dn_in(q_dn_in), .q_dn_out(q_dn_out), .q_up_in(q_up_in), .q_up_out(q_up_out)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // reference from the requirement tables: {prop, gen, ovf, c_out, F}
  function automatic logic [7:0] ref_alu(input logic [2:0] src, input logic [2:0] fn,
                                         input logic [3:0] av, bv, qv, dv, input logic ci);
    logic [3:0] r, s, x, z, fv;
    logic [4:0] sm, s0;
    logic [3:0] lo;
    logic co, ov, g, p;
    case (src)
      3'd0: begin r = av; s = qv; end
      3'd1: begin r = av; s = bv; end
      3'd2: begin r = 4'd0; s = qv; end
      3'd3: begin r = 4'd0; s = bv; end
      3'd4: begin r = 4'd0; s = av; end
      3'd5: begin r = dv; s = av; end
      3'd6: begin r = dv; s = qv; end
      default: begin r = dv; s = 4'd0; end
    endcase
    x = (fn == 3'd1) ? ~r : r;
    z = (fn == 3'd2) ? ~s : s;
    sm = {1'b0, x} + {1'b0, z} + {4'd0, ci};
    s0 = {1'b0, x} + {1'b0, z};
    lo = {1'b0, x[2:0]} + {1'b0, z[2:0]} + {3'd0, ci};
    co = 0; ov = 0; g = 0; p = 0;
    case (fn)
      3'd3: fv = r | s;
      3'd4: fv = r & s;
      3'd5: fv = ~r & s;
      3'd6: fv = r ^ s;
      3'd7: fv = ~(r ^ s);
      default: begin
        fv = sm[3:0]; co = sm[4]; ov = sm[4] ^ lo[3]; g = s0[4]; p = &(x | z);
      end
    endcase
    return {p, g, ov, co, fv};
  endfunction

  // one microinstruction: drive at falling edge, check mid-cycle, update shadow after rising edge
  task automatic step(input logic [2:0] src, fn, dst, input logic [3:0] a, b, d,
                      input logic ci, input logic [3:0] sin, input string tag);
    logic [7:0] res;
    logic [3:0] fv, ey, nrf, nq;
    logic erd, eru, eqd, equ, wrf, wq;
    @(negedge clk);
    instr = {dst, fn, src}; addr_a = a; addr_b = b; d_in = d; c_in = ci;
    {q_up_in, q_dn_in, rf_up_in, rf_dn_in} = sin;
    #2;
    res = ref_alu(src, fn, sh_rf[a], sh_rf[b], sh_q, d, ci);
    fv = res[3:0];
    ey = (dst == 3'd2) ? sh_rf[a] : fv;
    erd = 0; eru = 0; eqd = 0; equ = 0; wrf = (dst >= 3'd2); wq = 0;
    nrf = fv; nq = sh_q;
    case (dst)
      3'd0: begin wq = 1; nq = fv; end
      3'd4: begin nrf = {sin[0], fv[3:1]}; erd = fv[0]; wq = 1; nq = {sin[2], sh_q[3:1]}; eqd = sh_q[0]; end
      3'd5: begin nrf = {sin[0], fv[3:1]}; erd = fv[0]; end
      3'd6: begin nrf = {fv[2:0], sin[1]}; eru = fv[3]; wq = 1; nq = {sh_q[2:0], sin[3]}; equ = sh_q[3]; end
      3'd7: begin nrf = {fv[2:0], sin[1]}; eru = fv[3]; end
      default: ;
    endcase
    chk(y == ey, tag, "y", y, ey);
    chk({prop, gen, ovf, c_out} == res[7:4], tag, "p/g/ovf/cout", {prop, gen, ovf, c_out}, res[7:4]);
    chk(zero == (fv == 4'd0) && sign == fv[3], tag, "zero/sign (R5)", {zero, sign}, {(fv == 4'd0), fv[3]});
    chk({rf_dn_out, rf_up_out, q_dn_out, q_up_out} == {erd, eru, eqd, equ}, tag, "shift pins",
        {rf_dn_out, rf_up_out, q_dn_out, q_up_out}, {erd, eru, eqd, equ});
    @(posedge clk);
    #1;
    if (wrf) sh_rf[b] = nrf;
    if (wq)  sh_q = nq;
  endtask

  task automatic rd_reg(input logic [3:0] idx, input string tag);
    step(3'd4, 3'd0, 3'd1, idx, 4'd0, 4'd0, 1'b0, 4'd0, tag);
  endtask
  task automatic rd_q(input string tag);
    step(3'd2, 3'd0, 3'd1, 4'd0, 4'd0, 4'd0, 1'b0, 4'd0, tag);
  endtask

  task automatic t_reset;  // R1
    for (int i = 0; i < 16; i++) rd_reg(4'(i), "R1");
    rd_q("R1");
  endtask

  task automatic t_load;  // R1 R8
    for (int i = 0; i < 16; i++) step(3'd7, 3'd0, 3'd3, 4'd0, 4'(i), 4'(i * 5 + 3), 1'b0, 4'd0, "R8");
    step(3'd7, 3'd0, 3'd3, 4'd0, 4'd1, 4'd7, 1'b0, 4'd0, "R8");
    step(3'd7, 3'd0, 3'd3, 4'd0, 4'd2, 4'd1, 1'b0, 4'd0, "R8");
    step(3'd7, 3'd0, 3'd3, 4'd0, 4'd3, 4'd8, 1'b0, 4'd0, "R8");
    for (int i = 0; i < 16; i++) rd_reg(4'(i), "R1");
    step(3'd1, 3'd0, 3'd2, 4'd5, 4'd6, 4'd0, 1'b1, 4'd0, "R8");
    rd_reg(4'd6, "R8");
  endtask

  task automatic t_sources;  // R2
    step(3'd7, 3'd0, 3'd0, 4'd0, 4'd0, 4'd6, 1'b0, 4'd0, "R6");
    for (int s = 0; s < 8; s++) step(3'(s), 3'd0, 3'd1, 4'd4, 4'd9, 4'hA, 1'b0, 4'd0, "R2");
    for (int s = 0; s < 8; s++) step(3'(s), 3'd6, 3'd1, 4'd11, 4'd3, 4'h5, 1'b0, 4'd0, "R2");
  endtask

  task automatic t_funcs;  // R3 R4
    for (int fn = 0; fn < 8; fn++)
      for (int ci = 0; ci < 2; ci++) begin
        step(3'd1, 3'(fn), 3'd1, 4'd1, 4'd2, 4'd0, 1'(ci), 4'd0, "R3");
        step(3'd1, 3'(fn), 3'd1, 4'd3, 4'd1, 4'd0, 1'(ci), 4'd0, "R3");
        step(3'd5, 3'(fn), 3'd1, 4'd12, 4'd0, 4'hF, 1'(ci), 4'd0, "R4");
      end
    step(3'd1, 3'd0, 3'd1, 4'd1, 4'd2, 4'd0, 1'b0, 4'd0, "R4");  // 7+1 signed overflow
    step(3'd1, 3'd0, 3'd1, 4'd3, 4'd3, 4'd0, 1'b0, 4'd0, "R4");  // 8+8 carry out
    step(3'd5, 3'd0, 3'd1, 4'd2, 4'd0, 4'hF, 1'b1, 4'd0, "R4");  // full propagate chain
    step(3'd1, 3'd6, 3'd1, 4'd5, 4'd5, 4'd0, 1'b0, 4'd0, "R5");  // XOR to zero
  endtask

  task automatic t_dest;  // R6 R7 R9 R10 R11
    step(3'd7, 3'd0, 3'd0, 4'd0, 4'd9, 4'hB, 1'b0, 4'd0, "R6");
    rd_reg(4'd9, "R6"); rd_q("R6");
    step(3'd5, 3'd0, 3'd1, 4'd9, 4'd9, 4'h2, 1'b1, 4'd0, "R7");
    rd_reg(4'd9, "R7"); rd_q("R7");
    step(3'd7, 3'd0, 3'd4, 4'd0, 4'd10, 4'h9, 1'b0, 4'b0101, "R9");
    rd_reg(4'd10, "R9"); rd_q("R9");
    step(3'd7, 3'd0, 3'd4, 4'd0, 4'd10, 4'h6, 1'b0, 4'b0000, "R9");
    rd_reg(4'd10, "R9"); rd_q("R9");
    step(3'd7, 3'd0, 3'd5, 4'd0, 4'd11, 4'h3, 1'b0, 4'b0101, "R11");
    rd_reg(4'd11, "R9"); rd_q("R11");
    step(3'd7, 3'd0, 3'd6, 4'd0, 4'd12, 4'hC, 1'b0, 4'b1010, "R10");
    rd_reg(4'd12, "R10"); rd_q("R10");
    step(3'd7, 3'd0, 3'd6, 4'd0, 4'd12, 4'h5, 1'b0, 4'b0000, "R10");
    rd_reg(4'd12, "R10"); rd_q("R10");
    step(3'd7, 3'd0, 3'd7, 4'd0, 4'd13, 4'h9, 1'b0, 4'b1010, "R11");
    rd_reg(4'd13, "R10"); rd_q("R11");
  endtask

  initial begin
    #(200000 * 10);
    nbad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) sh_rf[i] = 4'd0;
    sh_q = 4'd0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_load();
    t_sources();
    t_funcs();
    t_dest();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule